// File: doc/BRIEF.md
# Serial Audio Interface Operation Control Register

This block is the run-control word of a serial audio port. One 32-bit register carries three live bits: a global run bit, a transmit enable and a receive enable. The block uses them to decide whether transmit words written by the CPU or a DMA engine enter the transmit FIFO, and whether words arriving from the serial receive path enter the receive FIFO. Both FIFOs are modelled here only as occupancy counters. The DMA request lines are also qualified by these bits.

A write that leaves an enable bit at 0 sends a one-cycle flush pulse to the matching FIFO. The same holds for the run bit, which covers both FIFOs. The flush pulse also tells a busy DMA channel to stop. While the interface runs, the bank of clock and mode configuration registers is write-protected. A write attempt during that time is rejected and sets a sticky error flag. Software clears this flag by writing 1 to it.

All accesses go through one write port and one combinational read port, using word addresses. Address 0 is the operation register. Address 1 is the status register. Addresses 2 to 2+NCFG-1 are the configuration registers.

Top module: `sai_opctl`

## Requirements
- R1: After reset, every register reads 0, both FIFO levels are 0, and no flush, DMA request or DMA stop output is active.
- R2: The operation register at address 0 keeps run in bit 0, transmit enable in bit 16 and receive enable in bit 24. All other bits ignore writes and read as 0.
- R3: A transmit push raises the transmit level by one at the next edge only while run and transmit enable are both 1. Otherwise the level does not rise.
- R4: A receive push raises the receive level by one at the next edge only while run and receive enable are both 1. Otherwise the level does not rise.
- R5: A write to address 0 with bit 0 or bit 16 at 0 drives the transmit flush high for the one cycle after the write edge. A write with bit 0 or bit 24 at 0 does the same for the receive flush. This holds even when the bit was already 0.
- R6: At the edge that ends a flush pulse, the flushed level becomes 0, regardless of any push or pop in that cycle.
- R7: A DMA stop output is high exactly while its flush pulse is high and its channel reports busy.
- R8: The transmit DMA request is high when run and transmit enable are 1 and the transmit level is at most TX_WM. The receive DMA request is high when run and receive enable are 1 and the receive level is at least RX_WM.
- R9: Configuration registers at addresses 2 to 2+NCFG-1 take a write while run is 0. While run is 1, they keep their contents.
- R10: A configuration write rejected by R9 sets status bit 0 at the next edge. The bit stays set until a status write with bit 0 at 1 clears it. A status write with bit 0 at 0 leaves it set.
- R11: A push at level DEPTH is dropped and a pop at level 0 is ignored. A push and a pop in the same cycle leave the level unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | AW | Write word address |
| wr_data | input | 32 | Write data |
| rd_addr | input | AW | Read word address |
| rd_data | output | 32 | Combinational read data |
| tx_push | input | 1 | Transmit word offered by CPU or DMA |
| tx_pop | input | 1 | Transmit word consumed by the serial side |
| rx_push | input | 1 | Received serial word offered |
| rx_pop | input | 1 | Received word read out |
| tx_dma_busy | input | 1 | Transmit DMA channel mid-transfer |
| rx_dma_busy | input | 1 | Receive DMA channel mid-transfer |
| tx_level | output | LW | Transmit FIFO occupancy |
| rx_level | output | LW | Receive FIFO occupancy |
| tx_flush | output | 1 | Transmit FIFO flush pulse |
| rx_flush | output | 1 | Receive FIFO flush pulse |
| tx_dma_req | output | 1 | Qualified transmit DMA request |
| rx_dma_req | output | 1 | Qualified receive DMA request |
| tx_dma_stop | output | 1 | Transmit DMA stop |
| rx_dma_stop | output | 1 | Receive DMA stop |
| cfg_q | output | NCFG*32 | Configuration register contents |

## Verification
Register contents, levels, flush pulses and the error flag are all due one edge after the write or push that causes them. A level cleared by a flush is due one edge later, when the pulse ends. Reads, DMA requests and DMA stops are combinational on that state, so they are valid in the same cycle the state is. The bench drives each stimulus on a falling edge and samples every output on the next falling edge. Its model advances in one step, using pre-edge values, so a flush raised by a write is expected one sample after the write and the cleared level one sample after that.

// File: rtl/sai_opctl_pkg.sv
package sai_opctl_pkg;
   localparam int REG_W    = 32;
   // operation register bit positions (software decodes these)
   localparam int RUN_BIT  = 0;
   localparam int TXE_BIT  = 16;
   localparam int RXE_BIT  = 24;
   localparam int ERR_BIT  = 0;
   // word address map
   localparam int A_OP     = 0;
   localparam int A_STAT   = 1;
   localparam int A_CFG0   = 2;

   typedef struct packed {
      logic rx_en;
      logic tx_en;
      logic run;
   } opctl_t;

   function automatic logic [REG_W-1:0] op_word(opctl_t o);
      logic [REG_W-1:0] w;
      w = '0;
      w[RUN_BIT] = o.run;
      w[TXE_BIT] = o.tx_en;
      w[RXE_BIT] = o.rx_en;
      return w;
   endfunction
endpackage

// File: rtl/sai_opctl_ctl.sv
module sai_opctl_ctl
   import sai_opctl_pkg::*;
#(
   parameter int AW   = 3,
   parameter int NCFG = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [AW-1:0] wr_addr,
   input  logic          wb_run,
   input  logic          wb_txe,
   input  logic          wb_rxe,
   output opctl_t        op,
   output logic          tx_flush,
   output logic          rx_flush,
   output logic          err,
   output logic          cfg_we
);
   logic op_hit, stat_hit, cfg_hit;

   assign op_hit   = wr_en && (wr_addr == AW'(A_OP));
   assign stat_hit = wr_en && (wr_addr == AW'(A_STAT));
   assign cfg_hit  = wr_en && (int'(wr_addr) >= A_CFG0) && (int'(wr_addr) < A_CFG0 + NCFG);
   assign cfg_we   = cfg_hit && !op.run;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         op       <= '0;
         tx_flush <= 1'b0;
         rx_flush <= 1'b0;
      end else begin
         tx_flush <= op_hit && !(wb_run && wb_txe);
         rx_flush <= op_hit && !(wb_run && wb_rxe);
         if (op_hit) begin
            op.run   <= wb_run;
            op.tx_en <= wb_txe;
            op.rx_en <= wb_rxe;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         err <= 1'b0;
      else if (cfg_hit && op.run)
         err <= 1'b1;
      else if (stat_hit && wb_run)
         err <= 1'b0;
   end
endmodule

// File: rtl/sai_opctl_cfg.sv
module sai_opctl_cfg
   import sai_opctl_pkg::*;
#(
   parameter int AW   = 3,
   parameter int NCFG = 4
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   cfg_we,
   input  logic [AW-1:0]          wr_addr,
   input  logic [REG_W-1:0]       wr_data,
   output logic [NCFG*REG_W-1:0]  cfg_q
);
   for (genvar i = 0; i < NCFG; i++) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            cfg_q[i*REG_W +: REG_W] <= '0;
         else if (cfg_we && (wr_addr == AW'(A_CFG0 + i)))
            cfg_q[i*REG_W +: REG_W] <= wr_data;
      end
   end
endmodule

// File: rtl/sai_opctl_lvl.sv
module sai_opctl_lvl #(
   parameter int DEPTH    = 8,
   parameter int WM       = 2,
   parameter bit REQ_HIGH = 1'b0,
   localparam int LW      = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push,
   input  logic          pop,
   input  logic          flush,
   output logic [LW-1:0] level,
   output logic          req
);
   logic push_v, pop_v;

   assign push_v = push && (level != LW'(DEPTH));
   assign pop_v  = pop  && (level != '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         level <= '0;
      else if (flush)
         level <= '0;
      else if (push_v && !pop_v)
         level <= level + 1'b1;
      else if (pop_v && !push_v)
         level <= level - 1'b1;
   end

   if (REQ_HIGH) begin : g_req_fill
      assign req = (level >= LW'(WM));
   end else begin : g_req_drain
      assign req = (level <= LW'(WM));
   end
endmodule

// File: rtl/sai_opctl.sv
module sai_opctl
   import sai_opctl_pkg::*;
#(
   parameter int AW    = 3,
   parameter int NCFG  = 4,
   parameter int DEPTH = 8,
   parameter int TX_WM = 2,
   parameter int RX_WM = 6,
   localparam int LW   = $clog2(DEPTH + 1)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  wr_en,
   input  logic [AW-1:0]         wr_addr,
   input  logic [31:0]           wr_data,
   input  logic [AW-1:0]         rd_addr,
   output logic [31:0]           rd_data,
   input  logic                  tx_push,
   input  logic                  tx_pop,
   input  logic                  rx_push,
   input  logic                  rx_pop,
   input  logic                  tx_dma_busy,
   input  logic                  rx_dma_busy,
   output logic [LW-1:0]         tx_level,
   output logic [LW-1:0]         rx_level,
   output logic                  tx_flush,
   output logic                  rx_flush,
   output logic                  tx_dma_req,
   output logic                  rx_dma_req,
   output logic                  tx_dma_stop,
   output logic                  rx_dma_stop,
   output logic [NCFG*32-1:0]    cfg_q
);
   if (DEPTH < 1) begin : g_bad_depth
      $error("sai_opctl: DEPTH must be at least 1");
   end
   if (TX_WM > DEPTH || RX_WM > DEPTH) begin : g_bad_wm
      $error("sai_opctl: watermarks must not exceed DEPTH");
   end
   if (A_CFG0 + NCFG > (1 << AW)) begin : g_bad_map
      $error("sai_opctl: AW too narrow for the register map");
   end

   opctl_t op;
   logic   err, cfg_we;
   logic   wb_run, wb_txe, wb_rxe;
   logic   tx_lvl_req, rx_lvl_req;

   assign wb_run = wr_data[RUN_BIT];
   assign wb_txe = wr_data[TXE_BIT];
   assign wb_rxe = wr_data[RXE_BIT];

   sai_opctl_ctl #(.AW(AW), .NCFG(NCFG)) ctl_i (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wb_run(wb_run), .wb_txe(wb_txe), .wb_rxe(wb_rxe),
      .op(op), .tx_flush(tx_flush), .rx_flush(rx_flush),
      .err(err), .cfg_we(cfg_we)
   );

   sai_opctl_cfg #(.AW(AW), .NCFG(NCFG)) cfg_i (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .wr_addr(wr_addr),
      .wr_data(wr_data), .cfg_q(cfg_q)
   );

   sai_opctl_lvl #(.DEPTH(DEPTH), .WM(TX_WM), .REQ_HIGH(1'b0)) tx_lvl_i (
      .clk(clk), .rst_n(rst_n), .push(tx_push && op.run && op.tx_en),
      .pop(tx_pop), .flush(tx_flush), .level(tx_level), .req(tx_lvl_req)
   );

   sai_opctl_lvl #(.DEPTH(DEPTH), .WM(RX_WM), .REQ_HIGH(1'b1)) rx_lvl_i (
      .clk(clk), .rst_n(rst_n), .push(rx_push && op.run && op.rx_en),
      .pop(rx_pop), .flush(rx_flush), .level(rx_level), .req(rx_lvl_req)
   );

   assign tx_dma_req  = tx_lvl_req && op.run && op.tx_en;
   assign rx_dma_req  = rx_lvl_req && op.run && op.rx_en;
   assign tx_dma_stop = tx_flush && tx_dma_busy;
   assign rx_dma_stop = rx_flush && rx_dma_busy;

   always_comb begin
      rd_data = '0;
      if (rd_addr == AW'(A_OP))
         rd_data = op_word(op);
      else if (rd_addr == AW'(A_STAT))
         rd_data[ERR_BIT] = err;
      else
         for (int i = 0; i < NCFG; i++)
            if (rd_addr == AW'(A_CFG0 + i))
               rd_data = cfg_q[i*32 +: 32];
   end
endmodule

// File: rtl/sai_opctl_chk.sv
module sai_opctl_chk
   import sai_opctl_pkg::*;
#(
   parameter int AW    = 3,
   parameter int NCFG  = 4,
   parameter int DEPTH = 8,
   parameter int TX_WM = 2,
   parameter int RX_WM = 6,
   localparam int LW   = $clog2(DEPTH + 1)
) (
   input logic               clk,
   input logic               rst_n,
   input logic               wr_en,
   input logic [AW-1:0]      wr_addr,
   input logic               wb_run,
   input logic               wb_txe,
   input logic               wb_rxe,
   input opctl_t             op,
   input logic               err,
   input logic               tx_flush,
   input logic               rx_flush,
   input logic [LW-1:0]      tx_level,
   input logic [LW-1:0]      rx_level,
   input logic               tx_dma_req,
   input logic               rx_dma_req,
   input logic               tx_dma_stop,
   input logic               rx_dma_stop,
   input logic [NCFG*32-1:0] cfg_q
);
   logic op_wr, stat_wr, cfg_wr;
   assign op_wr   = wr_en && (wr_addr == AW'(A_OP));
   assign stat_wr = wr_en && (wr_addr == AW'(A_STAT));
   assign cfg_wr  = wr_en && (int'(wr_addr) >= A_CFG0) && (int'(wr_addr) < A_CFG0 + NCFG);

   // R3
   tx_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(op.run && op.tx_en) |=> (tx_level <= $past(tx_level)));
   // R4
   rx_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(op.run && op.rx_en) |=> (rx_level <= $past(rx_level)));
   // R5
   tx_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op_wr && !(wb_run && wb_txe)) |=> tx_flush);
   // R5
   tx_flush_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(op_wr && !(wb_run && wb_txe)) |=> !tx_flush);
   // R5
   rx_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op_wr && !(wb_run && wb_rxe)) |=> rx_flush);
   // R6
   tx_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tx_flush |=> (tx_level == '0));
   // R6
   rx_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rx_flush |=> (rx_level == '0));
   // R7
   tx_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !tx_flush |-> !tx_dma_stop);
   // R7
   rx_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rx_flush |-> !rx_dma_stop);
   // R8
   tx_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tx_dma_req |-> (op.run && op.tx_en && tx_level <= LW'(TX_WM)));
   // R8
   rx_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rx_dma_req |-> (op.run && op.rx_en && rx_level >= LW'(RX_WM)));
   // R9
   cfg_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_wr && op.run) |=> $stable(cfg_q));
   // R10
   err_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_wr && op.run) |=> err);
   // R10
   err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (err && !(stat_wr && wb_run)) |=> err);
   // R11
   lvl_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_level <= LW'(DEPTH)) && (rx_level <= LW'(DEPTH)));
endmodule

bind sai_opctl sai_opctl_chk #(
   .AW(AW), .NCFG(NCFG), .DEPTH(DEPTH), .TX_WM(TX_WM), .RX_WM(RX_WM)
) chk_i (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
   .wb_run(wb_run), .wb_txe(wb_txe), .wb_rxe(wb_rxe), .op(op), .err(err),
   .tx_flush(tx_flush), .rx_flush(rx_flush), .tx_level(tx_level), .rx_level(rx_level),
   .tx_dma_req(tx_dma_req), .rx_dma_req(rx_dma_req),
   .tx_dma_stop(tx_dma_stop), .rx_dma_stop(rx_dma_stop), .cfg_q(cfg_q)
);

// File: tb/sai_opctl_tb_top.sv
module sai_opctl_tb_top;
   localparam int AW = 3, NCFG = 4, DEPTH = 8, TX_WM = 2, RX_WM = 6;
   localparam int LW = $clog2(DEPTH + 1);

   logic clk = 1'b0, rst_n = 1'b0;
   logic wr_en = 1'b0, tx_push = 1'b0, tx_pop = 1'b0, rx_push = 1'b0, rx_pop = 1'b0;
   logic tx_dma_busy = 1'b0, rx_dma_busy = 1'b0;
   logic [AW-1:0] wr_addr = '0, rd_addr = '0;
   logic [31:0] wr_data = '0, rd_data;
   logic [LW-1:0] tx_level, rx_level;
   logic tx_flush, rx_flush, tx_dma_req, rx_dma_req, tx_dma_stop, rx_dma_stop;
   logic [NCFG*32-1:0] cfg_q;

   sai_opctl #(.AW(AW), .NCFG(NCFG), .DEPTH(DEPTH), .TX_WM(TX_WM), .RX_WM(RX_WM)) dut_i (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_addr(rd_addr), .rd_data(rd_data), .tx_push(tx_push), .tx_pop(tx_pop),
      .rx_push(rx_push), .rx_pop(rx_pop), .tx_dma_busy(tx_dma_busy), .rx_dma_busy(rx_dma_busy),
      .tx_level(tx_level), .rx_level(rx_level), .tx_flush(tx_flush), .rx_flush(rx_flush),
      .tx_dma_req(tx_dma_req), .rx_dma_req(rx_dma_req), .tx_dma_stop(tx_dma_stop),
      .rx_dma_stop(rx_dma_stop), .cfg_q(cfg_q)
   );

   always #10 clk = ~clk;   // 50 MHz

   int  vecs = 0, errs = 0, rsel = 0;
   bit  done = 1'b0;
   bit  m_run, m_tx, m_rx, m_err, m_txf, m_rxf;
   int  m_txl, m_rxl;
   logic [31:0] m_cfg [NCFG];

   task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
      vecs++;
      if (act !== exp) begin
         errs++;
         $display("FAIL %s %s: got %h expected %h", tag, what, act, exp);
      end
   endtask

   function automatic logic [31:0] exp_rd(int a);
      logic [31:0] r = '0;
      if (a == 0) begin r[0] = m_run; r[16] = m_tx; r[24] = m_rx; end
      else if (a == 1) r[0] = m_err;
      else if (a >= 2 && a < 2 + NCFG) r = m_cfg[a-2];
      return r;
   endfunction

   // one clock: drive on a falling edge, sample on the next falling edge
   task automatic cyc(string tag, bit w, int a, logic [31:0] d,
                      bit tp, bit tpo, bit rp, bit rpo);
      int  ntx, nrx;
      bit  nf_tx, nf_rx;
      wr_en = w; wr_addr = AW'(a); wr_data = d;
      tx_push = tp; tx_pop = tpo; rx_push = rp; rx_pop = rpo;
      rd_addr = AW'(rsel);
      @(negedge clk);
      if (m_txf) ntx = 0;
      else ntx = m_txl + int'(tp && m_run && m_tx && m_txl < DEPTH) - int'(tpo && m_txl > 0);
      if (m_rxf) nrx = 0;
      else nrx = m_rxl + int'(rp && m_run && m_rx && m_rxl < DEPTH) - int'(rpo && m_rxl > 0);
      nf_tx = w && a == 0 && !(d[0] && d[16]);
      nf_rx = w && a == 0 && !(d[0] && d[24]);
      if (w && a >= 2 && a < 2 + NCFG) begin
         if (m_run) m_err = 1'b1; else m_cfg[a-2] = d;
      end
      if (w && a == 1 && d[0]) m_err = 1'b0;
      if (w && a == 0) begin m_run = d[0]; m_tx = d[16]; m_rx = d[24]; end
      m_txl = ntx; m_rxl = nrx; m_txf = nf_tx; m_rxf = nf_rx;
      wr_en = 1'b0; tx_push = 1'b0; tx_pop = 1'b0; rx_push = 1'b0; rx_pop = 1'b0;
      chk(tag, "tx_level", 32'(tx_level), 32'(m_txl));
      chk(tag, "rx_level", 32'(rx_level), 32'(m_rxl));
      chk(tag, "tx_flush", 32'(tx_flush), 32'(m_txf));
      chk(tag, "rx_flush", 32'(rx_flush), 32'(m_rxf));
      chk(tag, "tx_dma_req", 32'(tx_dma_req), 32'(m_run && m_tx && m_txl <= TX_WM));
      chk(tag, "rx_dma_req", 32'(rx_dma_req), 32'(m_run && m_rx && m_rxl >= RX_WM));
      chk(tag, "tx_dma_stop", 32'(tx_dma_stop), 32'(m_txf && tx_dma_busy));
      chk(tag, "rx_dma_stop", 32'(rx_dma_stop), 32'(m_rxf && rx_dma_busy));
      chk(tag, "rd_data", rd_data, exp_rd(rsel));
   endtask

   task automatic wop(string tag, bit r, bit t, bit x);
      cyc(tag, 1'b1, 0, {7'd0, x, 7'd0, t, 15'd0, r}, 0, 0, 0, 0);
   endtask

   task automatic idle(string tag);
      cyc(tag, 1'b0, 0, 32'd0, 0, 0, 0, 0);
   endtask

   task automatic summary();
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
   endtask

   initial begin
      #(20 * 50000);
      if (!done) begin
         errs++;
         $display("FAIL watchdog (all requirements): got timeout expected completion");
         summary();
         $finish;
      end
   end

   initial begin
      m_run = 0; m_tx = 0; m_rx = 0; m_err = 0; m_txf = 0; m_rxf = 0;
      m_txl = 0; m_rxl = 0;
      for (int i = 0; i < NCFG; i++) m_cfg[i] = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1: reset state over every address
      for (int a = 0; a < 2 + NCFG; a++) begin rsel = a; idle("R1"); end

      // R2: reserved bits set together with every live-bit pattern
      rsel = 0;
      for (int v = 0; v < 8; v++)
         cyc("R2", 1, 0, 32'hFEFE_FFFE | {7'd0, v[2], 7'd0, v[1], 15'd0, v[0]}, 0, 0, 0, 0);
      wop("R2", 0, 0, 0); idle("R2");

      // R3: transmit push gating for all enable patterns
      for (int v = 0; v < 8; v++) begin
         wop("R3", v[0], v[1], v[2]);
         cyc("R3", 0, 0, 0, 1, 0, 0, 0);
         cyc("R3", 0, 0, 0, 1, 0, 0, 0);
         wop("R3", 0, 0, 0); idle("R3");
      end
      // R4: receive push gating for all enable patterns
      for (int v = 0; v < 8; v++) begin
         wop("R4", v[0], v[1], v[2]);
         cyc("R4", 0, 0, 0, 0, 0, 1, 0);
         cyc("R4", 0, 0, 0, 0, 0, 1, 0);
         wop("R4", 0, 0, 0); idle("R4");
      end

      // R5: flush pulses, including repeated clears
      wop("R5", 1, 1, 1); idle("R5");
      wop("R5", 1, 0, 1); wop("R5", 1, 0, 1); idle("R5");
      wop("R5", 1, 1, 0); idle("R5");
      wop("R5", 0, 1, 1); idle("R5");
      wop("R5", 0, 0, 0); wop("R5", 1, 1, 1); idle("R5");

      // R6: flush beats push and pop in the clearing cycle
      for (int i = 0; i < 5; i++) cyc("R6", 0, 0, 0, 1, 0, 1, 0);
      cyc("R6", 1, 0, 32'h0100_0001, 1, 0, 1, 0);
      cyc("R6", 0, 0, 0, 1, 1, 1, 1);
      idle("R6");
      cyc("R6", 1, 0, 32'h0001_0001, 1, 0, 1, 0);
      cyc("R6", 0, 0, 0, 1, 1, 1, 1);
      idle("R6");

      // R7: DMA stop needs both flush and busy
      tx_dma_busy = 1; rx_dma_busy = 1;
      wop("R7", 1, 1, 1); wop("R7", 1, 0, 1); wop("R7", 0, 1, 1); idle("R7");
      tx_dma_busy = 0;
      wop("R7", 1, 1, 1); wop("R7", 0, 0, 0); idle("R7");
      rx_dma_busy = 0;
      wop("R7", 1, 1, 1); wop("R7", 0, 0, 0); idle("R7");

      // R8: request thresholds across every level, then enable qualification
      wop("R8", 1, 1, 1); idle("R8");
      for (int i = 0; i <= DEPTH; i++) cyc("R8", 0, 0, 0, 1, 0, 1, 0);
      wop("R8", 1, 1, 0); wop("R8", 1, 1, 1);
      for (int i = 0; i < DEPTH; i++) cyc("R8", 0, 0, 0, 1, 0, 1, 0);
      for (int i = 0; i <= DEPTH; i++) cyc("R8", 0, 0, 0, 0, 1, 0, 1);
      wop("R8", 1, 0, 1); idle("R8");
      wop("R8", 0, 1, 1); idle("R8");

      // R9: configuration writes while stopped, then rejected while running
      for (int i = 0; i < NCFG; i++) begin
         rsel = 2 + i;
         cyc("R9", 1, 2 + i, 32'hA500_0000 + 32'(i) * 32'h0001_1111, 0, 0, 0, 0);
      end
      wop("R9", 1, 0, 0);
      for (int i = 0; i < NCFG; i++) begin
         rsel = 2 + i;
         cyc("R9", 1, 2 + i, 32'h5A5A_5A5A, 0, 0, 0, 0);
         idle("R9");
      end
      // R10: sticky error flag
      rsel = 1;
      idle("R10");
      cyc("R10", 1, 1, 32'hFFFF_FFFE, 0, 0, 0, 0);
      cyc("R10", 1, 1, 32'h0000_0001, 0, 0, 0, 0);
      cyc("R10", 1, 2, 32'h1234_5678, 0, 0, 0, 0);
      idle("R10");
      wop("R10", 0, 0, 0);
      cyc("R10", 1, 1, 32'h0000_0001, 0, 0, 0, 0);
      cyc("R10", 1, 3, 32'h1234_5678, 0, 0, 0, 0);
      idle("R10");

      // R11: saturation at both ends and simultaneous push and pop
      rsel = 0;
      wop("R11", 1, 1, 1);
      for (int i = 0; i < DEPTH + 3; i++) cyc("R11", 0, 0, 0, 1, 0, 1, 0);
      cyc("R11", 0, 0, 0, 1, 1, 1, 1);
      for (int i = 0; i < DEPTH + 3; i++) cyc("R11", 0, 0, 0, 0, 1, 0, 1);
      cyc("R11", 0, 0, 0, 1, 1, 1, 1);
      idle("R11");

      done = 1'b1;
      summary();
      $finish;
   end
endmodule